// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog peripheral on a plain 32-bit write/read register bus. Every control action is guarded by a 16-bit key value written to a dedicated register: restarting the countdown, turning the timer off, turning it back on, and clearing the sticky timeout record. Turning the timer off takes two consecutive keyed writes to two different registers. An interrupted sequence is thrown away.

The countdown runs in ticks of nominally 10 ms. A prescaler produces the ticks and restarts on every accepted feed. One tick before expiry the block raises a pre-timeout event, which can be masked, acknowledged or forced by software. On expiry it drives a reset pulse of fixed length and records the timeout in a sticky status word. It then reloads the last programmed timeout and keeps counting.

The remaining count can be read back. A flag in that register tells the reader that the value has just changed and is not yet settled. A debug input stops the countdown unless software has set an override bit.

Top module: `kwd_top`

## Requirements
- R1: After reset the timer is off: the state register (0x0C) reads 0xDABE, status (0x10) reads 0x0000, the event register (0x20) reads 0, `irq` and `sys_rst` are low, and the count register (0x14) reads RESET_TMO with bit 15 clear.
- R2: The timeout register (0x04) keeps only the low 15 bits of a write and reads them back zero-extended. Writing it does not reload the count.
- R3: A write of exactly 0x0000FEED to 0x00 while the timer is on does three things: it loads the count from the timeout register, starts counting and restarts the tick prescaler. Any other value, and any feed while the timer is off, leaves the count unchanged.
- R4: While counting, the count (bits 14:0 of 0x14) drops by one every TICK_DIV clocks. The first step comes TICK_DIV clocks after the feed.
- R5: Bit 15 of 0x14 reads 1 for SETTLE clocks after every load or step of the count, and 0 otherwise.
- R6: A write of 0xCAFE to 0x0C turns the timer off only if the bus write immediately before it was 0x2BAD to 0x08. While the timer is off, 0x0C reads 0xDABE and the count holds. While it is on, 0x0C reads 0x0000.
- R7: A write of 0xACED to 0x1C turns the timer on (0x0C reads 0x0000). Other values are ignored. Counting begins only with the next feed.
- R8: The pre-timeout event (bit 0 of 0x20) sets on the step that brings the count to 1. Writing 1 to bit 0 of 0x20 clears it. `irq` is the event gated by bit 0 of 0x24.
- R9: While bit 0 of 0x28 is 1, the event is held set. This takes priority over an acknowledge.
- R10: A step taken at count 1 or 0 is an expiry. It drives `sys_rst` high for RST_PULSE clocks, sets status to 0xCFE8, and reloads the count from the timeout register.
- R11: Status returns to 0x0000 only on a write of 0xE8B4 to 0x10. Other values leave it unchanged.
- R12: 0x18 reads `dbg_mode` in bit 1 and the override flag in bit 0. While `dbg_mode` is high and the override is 0, the count holds.
- R13: Writes and reads with a nonzero value in address bits 1:0 are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_mode | input | 1 | Debug session active; stops the countdown unless overridden |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | Masked pre-timeout interrupt |
| sys_rst | output | 1 | System reset pulse on expiry |

## Verification
The bench builds the block with TICK_DIV = 4, SETTLE = 3, RST_PULSE = 5 and RESET_TMO = 7. Each tick then takes only four clocks, so the bench can sweep every timeout from 2 to 6 through to expiry. It checks the count, the settle flag, the interrupt and the reset line on every single clock of that sweep. The settle window is shorter than a tick, and the reset pulse is shorter than the smallest timeout period. This keeps both the flag's falling edge and the end of the pulse visible. It also keeps the disable sequence, the debug hold and the force/acknowledge interplay within a few dozen clocks each.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
  localparam logic [15:0] KEY_FEED   = 16'hFEED;
  localparam logic [15:0] KEY_ARM    = 16'h2BAD;
  localparam logic [15:0] KEY_KILL   = 16'hCAFE;
  localparam logic [15:0] KEY_RESUME = 16'hACED;
  localparam logic [15:0] KEY_CLEAR  = 16'hE8B4;
  localparam logic [15:0] VAL_OFF    = 16'hDABE;
  localparam logic [15:0] VAL_BITTEN = 16'hCFE8;

  // word index = byte address / 4
  typedef enum logic [3:0] {
    IX_FEED = 4'd0, IX_TMO = 4'd1, IX_ARM = 4'd2, IX_KILL = 4'd3,
    IX_STAT = 4'd4, IX_CNT = 4'd5, IX_DBG = 4'd6, IX_RESUME = 4'd7,
    IX_EVT  = 4'd8, IX_MASK = 4'd9, IX_FORCE = 4'd10
  } reg_ix_e;
endpackage

// File: rtl/kwd_tick.sv
`timescale 1ns/1ps
module kwd_tick #(
  parameter int DIV = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              pre_q <= '0;
    else if (restart || tick) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/kwd_core.sv
`timescale 1ns/1ps
module kwd_core #(
  parameter int CNT_W     = 15,
  parameter int SETTLE    = 3,
  parameter int RST_PULSE = 16,
  parameter int RESET_TMO = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] tmo,
  output logic [CNT_W-1:0] cnt,
  output logic             unstable,
  output logic             pre_evt,
  output logic             expire,
  output logic             sys_rst
);
  localparam int SW  = $clog2(SETTLE + 1);
  localparam int PCW = $clog2(RST_PULSE + 1);

  // the step at count 1 (or 0) is the expiry
  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] reload);
    return is_last(c) ? reload : c - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [SW-1:0]    settle_q;
  logic [PCW-1:0]   pulse_q;

  assign expire  = step && !load && is_last(cnt_q);
  assign pre_evt = step && !load && (cnt_q == CNT_W'(2));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= CNT_W'(RESET_TMO);
    else if (load)  cnt_q <= tmo;
    else if (step)  cnt_q <= next_count(cnt_q, tmo);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                settle_q <= '0;
    else if (load || step)     settle_q <= SW'(SETTLE);
    else if (settle_q != '0)   settle_q <= settle_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               pulse_q <= '0;
    else if (expire)          pulse_q <= PCW'(RST_PULSE);
    else if (pulse_q != '0)   pulse_q <= pulse_q - 1'b1;
  end

  assign cnt      = cnt_q;
  assign unstable = (settle_q != '0);
  assign sys_rst  = (pulse_q != '0);
endmodule

// File: rtl/kwd_top.sv
`timescale 1ns/1ps
module kwd_top #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 15,
  parameter int TICK_DIV  = 320,
  parameter int SETTLE    = 3,
  parameter int RST_PULSE = 16,
  parameter int RESET_TMO = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              sys_rst
);
  import kwd_pkg::*;

  localparam int IX_W = ADDR_W - 2;

  function automatic logic keyed(input logic [DATA_W-1:0] d, input logic [15:0] k);
    return d == DATA_W'(k);
  endfunction

  // bus decode
  logic [IX_W-1:0] wr_ix, rd_ix;
  logic            wr_ok, rd_ok;
  assign wr_ix = wr_addr[ADDR_W-1:2];
  assign rd_ix = rd_addr[ADDR_W-1:2];
  assign wr_ok = wr_en && (wr_addr[1:0] == 2'b00);
  assign rd_ok = (rd_addr[1:0] == 2'b00);

  function automatic logic at(input logic [IX_W-1:0] ix, input reg_ix_e r);
    return ix == IX_W'(r);
  endfunction

  // state
  logic             en_q, run_q, armed_q, to_q, evt_q, msk_q, frc_q, ovr_q;
  logic [CNT_W-1:0] tmo_q;

  // named internal events
  logic feed_ok, arm_hit, kill_ok, resume_hit, clear_hit, ack_hit;
  logic tick, step, expire, pre_evt, cnt_unstable;
  logic [CNT_W-1:0] cnt_q;

  assign feed_ok    = wr_ok && at(wr_ix, IX_FEED)   && keyed(wr_data, KEY_FEED) && en_q;
  assign arm_hit    = wr_ok && at(wr_ix, IX_ARM)    && keyed(wr_data, KEY_ARM);
  assign kill_ok    = wr_ok && at(wr_ix, IX_KILL)   && keyed(wr_data, KEY_KILL) && armed_q;
  assign resume_hit = wr_ok && at(wr_ix, IX_RESUME) && keyed(wr_data, KEY_RESUME);
  assign clear_hit  = wr_ok && at(wr_ix, IX_STAT)   && keyed(wr_data, KEY_CLEAR);
  assign ack_hit    = wr_ok && at(wr_ix, IX_EVT)    && wr_data[0];
  assign step       = tick && en_q && run_q && (!dbg_mode || ovr_q);

  kwd_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(feed_ok), .tick(tick)
  );

  kwd_core #(
    .CNT_W(CNT_W), .SETTLE(SETTLE), .RST_PULSE(RST_PULSE), .RESET_TMO(RESET_TMO)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .load(feed_ok), .step(step), .tmo(tmo_q),
    .cnt(cnt_q), .unstable(cnt_unstable), .pre_evt(pre_evt),
    .expire(expire), .sys_rst(sys_rst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; run_q <= 1'b0; armed_q <= 1'b0;
      to_q <= 1'b0; evt_q <= 1'b0; msk_q <= 1'b0; frc_q <= 1'b0; ovr_q <= 1'b0;
      tmo_q <= CNT_W'(RESET_TMO);
    end else begin
      if (wr_ok) armed_q <= arm_hit;
      if (kill_ok) begin
        en_q <= 1'b0; run_q <= 1'b0;
      end else begin
        if (resume_hit) en_q  <= 1'b1;
        if (feed_ok)    run_q <= 1'b1;
      end
      if (expire)         to_q <= 1'b1;
      else if (clear_hit) to_q <= 1'b0;
      if (pre_evt || frc_q) evt_q <= 1'b1;
      else if (ack_hit)     evt_q <= 1'b0;
      if (wr_ok && at(wr_ix, IX_TMO))   tmo_q <= wr_data[CNT_W-1:0];
      if (wr_ok && at(wr_ix, IX_MASK))  msk_q <= wr_data[0];
      if (wr_ok && at(wr_ix, IX_FORCE)) frc_q <= wr_data[0];
      if (wr_ok && at(wr_ix, IX_DBG))   ovr_q <= wr_data[0];
    end
  end

  assign irq = evt_q && msk_q;

  logic [15:0] rd16;
  always_comb begin
    rd16 = '0;
    if (rd_ok) begin
      if (at(rd_ix, IX_TMO))   rd16 = 16'(tmo_q);
      if (at(rd_ix, IX_KILL))  rd16 = en_q ? 16'h0000 : VAL_OFF;
      if (at(rd_ix, IX_STAT))  rd16 = to_q ? VAL_BITTEN : 16'h0000;
      if (at(rd_ix, IX_CNT))   rd16 = 16'({cnt_unstable, cnt_q});
      if (at(rd_ix, IX_DBG))   rd16 = {14'b0, dbg_mode, ovr_q};
      if (at(rd_ix, IX_EVT))   rd16 = {15'b0, evt_q};
      if (at(rd_ix, IX_MASK))  rd16 = {15'b0, msk_q};
      if (at(rd_ix, IX_FORCE)) rd16 = {15'b0, frc_q};
    end
  end
  assign rd_data = {{(DATA_W-16){1'b0}}, rd16};
endmodule

// File: rtl/kwd_chk.sv
`timescale 1ns/1ps
module kwd_chk #(
  parameter int CNT_W     = 15,
  parameter int RST_PULSE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             armed,
  input logic             load,
  input logic             step,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic             unstable,
  input logic             sys_rst,
  input logic             status
);
  localparam int SW = $clog2(RST_PULSE + 1);

  // clocks since the last expiry, saturating
  logic [SW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                       since_q <= SW'(RST_PULSE);
    else if (expire)                  since_q <= '0;
    else if (since_q != SW'(RST_PULSE)) since_q <= since_q + 1'b1;
  end

  a_r6_kill_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> $past(armed));

  a_r6_off_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

  a_r5_flag_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step || load) |=> unstable);

  a_r10_status_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status);

  a_r10_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> (since_q < SW'(RST_PULSE)));
endmodule

bind kwd_top kwd_chk #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .armed(armed_q), .load(feed_ok),
  .step(step), .expire(expire), .cnt(cnt_q), .unstable(cnt_unstable),
  .sys_rst(sys_rst), .status(to_q)
);

// File: tb/test_kwd_top.sv
`timescale 1ns/1ps
module test_kwd_top;
  localparam int D  = 4;
  localparam int ST = 3;
  localparam int RP = 5;
  localparam int RT = 7;

  logic        clk = 1'b0, rst_n = 1'b0, dbg_mode = 1'b0, wr_en = 1'b0;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, sys_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kwd_top #(.TICK_DIV(D), .SETTLE(ST), .RST_PULSE(RP), .RESET_TMO(RT)) i_kwd_top (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    rd_addr = a; #0.2;
    v = rd_data;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1;
    edges(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(6'h0C, v); chk("R1 state", v, 32'hDABE);
    rd(6'h10, v); chk("R1 status", v, 0);
    rd(6'h14, v); chk("R1 count", v, RT);
    rd(6'h20, v); chk("R1 event", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sys_rst", sys_rst, 0);
    // R2 timeout width
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); chk("R2 mask", v, 32'h7FFF);
    rd(6'h14, v); chk("R2 no reload", v, RT);
    // R3 feed while off ignored
    wr(6'h04, 3); wr(6'h00, 32'hFEED); edges(3 * D);
    rd(6'h14, v); chk("R3 feed when off", v, RT);
    // R7 resume
    wr(6'h1C, 32'hACEE); rd(6'h0C, v); chk("R7 bad key", v, 32'hDABE);
    wr(6'h1C, 32'hACED); rd(6'h0C, v); chk("R7 on", v, 0);
    edges(2 * D); rd(6'h14, v); chk("R7 idle until feed", v, RT);
    // R3 wrong feed key, R13 unaligned feed
    wr(6'h00, 32'hFEEC); edges(2 * D); rd(6'h14, v); chk("R3 bad key", v, RT);
    wr(6'h01, 32'hFEED); edges(2 * D); rd(6'h14, v); chk("R13 unaligned", v, RT);
    rd(6'h05, v); chk("R13 unaligned read", v, 0);
    wr(6'h24, 1);
    // sweep timeouts R4 R5 R8 R10
    for (int t = 2; t <= 6; t++) begin
      wr(6'h08, 32'h2BAD); wr(6'h0C, 32'hCAFE); wr(6'h1C, 32'hACED);
      wr(6'h10, 32'hE8B4); wr(6'h20, 1); wr(6'h04, t);
      rd(6'h20, v); chk("R8 ack", v, 0);
      wr(6'h00, 32'hFEED);
      for (int n = 1; n < t * D; n++) begin
        edges(1);
        rd(6'h14, v);
        chk("R4 R5 count", v, (((n % D) < ST) ? 32'h8000 : 32'h0) | 32'(t - n / D));
        chk("R8 irq", irq, n >= (t - 1) * D);
        chk("R10 no early reset", sys_rst, 0);
      end
      edges(1);
      rd(6'h14, v); chk("R10 reload", v, 32'h8000 | t);
      rd(6'h10, v); chk("R10 status", v, 32'hCFE8);
      chk("R10 pulse start", sys_rst, 1);
      for (int m = 1; m <= RP; m++) begin
        edges(1);
        chk("R10 pulse", sys_rst, m < RP);
      end
      if (t == 2) begin
        wr(6'h10, 32'h1234); rd(6'h10, v); chk("R11 bad key", v, 32'hCFE8);
        wr(6'h10, 32'hE8B4); rd(6'h10, v); chk("R11 clear", v, 0);
      end
    end
    // R12 debug hold
    wr(6'h08, 32'h2BAD); wr(6'h0C, 32'hCAFE); wr(6'h1C, 32'hACED);
    dbg_mode = 1'b1;
    wr(6'h04, 5); wr(6'h00, 32'hFEED); edges(3 * D);
    rd(6'h14, v); chk("R12 hold", v & 32'h7FFF, 5);
    rd(6'h18, v); chk("R12 reg", v, 2);
    wr(6'h18, 1); rd(6'h18, v); chk("R12 override", v, 3);
    wr(6'h00, 32'hFEED); edges(D);
    rd(6'h14, v); chk("R12 runs", v & 32'h7FFF, 4);
    dbg_mode = 1'b0;
    // R6 disable handshake
    wr(6'h08, 32'h2BAD); wr(6'h04, 5); wr(6'h0C, 32'hCAFE);
    rd(6'h0C, v); chk("R6 interrupted", v, 0);
    wr(6'h08, 32'h2BAD); wr(6'h0C, 32'hCAFF);
    rd(6'h0C, v); chk("R6 bad key", v, 0);
    wr(6'h08, 32'h2BAD); wr(6'h0C, 32'hCAFE);
    rd(6'h0C, v); chk("R6 off", v, 32'hDABE);
    rd(6'h14, c1); edges(3 * D); rd(6'h14, v);
    chk("R6 frozen", v & 32'h7FFF, c1 & 32'h7FFF);
    // R9 force
    wr(6'h20, 1); wr(6'h28, 1); edges(1);
    rd(6'h20, v); chk("R9 force", v, 1);
    chk("R9 irq", irq, 1);
    wr(6'h20, 1); rd(6'h20, v); chk("R9 beats ack", v, 1);
    wr(6'h28, 0); wr(6'h20, 1); rd(6'h20, v); chk("R8 ack after force", v, 0);
    chk("R8 irq low", irq, 0);
    wr(6'h24, 0); wr(6'h28, 1); edges(1);
    chk("R8 masked", irq, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule